// File: doc/BRIEF.md
# UART receive FIFO with threshold interrupts

This block sits behind a byte-level UART receiver (8-N-1, ten bit times per character) and holds the received bytes in a 32-entry first-in first-out store until the host reads them. It raises a level-sensitive interrupt when the fill level reaches a threshold the host selects. The threshold can be a quarter, half, three quarters or all of the store. A per-byte mode raises the request as soon as any byte is present. An idle timer also raises a request when bytes sit below the threshold for four character times with nothing new arriving, so the tail of a packet is always reported.

The byte input is a valid-only stream. The deserializer cannot be stalled, so there is no back-pressure on it. A byte that finds the store full, with no read in the same cycle, is discarded and recorded in a sticky overflow flag. The read side is valid/ready. `out_valid` is high whenever a byte is held, and `out_data` shows the oldest byte. A byte is consumed on any clock edge where both `out_valid` and `out_ready` are high. The host can keep `out_ready` high as long as it likes. The 6-bit level output lets the host drain exactly the bytes present.

Top module: `uart_rxq`

## Requirements
- R1: After reset, level is 0, out_valid is 0, overflow is 0, and irq_level, irq_timeout and irq are all 0.
- R2: Bytes leave in arrival order. out_valid is 1 exactly when level is nonzero, and out_data shows the oldest held byte.
- R3: level (6 bits) counts accepted bytes minus consumed bytes. It changes on the clock edge that takes the write or read.
- R4: The thr_sel encoding sets when irq_level is 1. Code 0 needs level at least 1. Code 1 needs at least 8, code 2 at least 16 and code 3 at least 24. Codes 4 to 7 need level 32. irq_level follows thr_sel and level within the same cycle.
- R5: irq_level drops once reads bring level below the selected threshold.
- R6: A byte that arrives while level is 32, with no read in that cycle, is dropped. Stored contents and level stay unchanged, and overflow is 1 after that edge.
- R7: overflow stays set until a cycle with status_rd high clears it. If a drop happens in the same cycle as status_rd, overflow stays set.
- R8: An arriving byte together with a read in the same cycle leaves level unchanged and never sets overflow, even at level 32. The new byte is stored.
- R9: irq_timeout rises on the 160th clock edge after the last arrival or read, while the FIFO is non-empty. That is 4 characters of 10 bit times at 4 clocks per bit. It then holds until a byte is read, and new arrivals do not clear it.
- R10: irq is the OR of irq_level and irq_timeout.
- R11: An arrival or a read restarts the idle count. An empty FIFO never raises irq_timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present this cycle (no back-pressure) |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | A byte is held for the host |
| out_ready | input | 1 | Host takes the byte shown on out_data |
| out_data | output | 8 | Oldest held byte |
| thr_sel | input | 3 | Interrupt threshold code (see R4) |
| status_rd | input | 1 | Status read strobe, clears overflow |
| level | output | 6 | Number of held bytes, 0 to 32 |
| overflow | output | 1 | Sticky flag: a byte was dropped |
| irq_level | output | 1 | Fill-level threshold request |
| irq_timeout | output | 1 | Idle-timeout request |
| irq | output | 1 | Combined interrupt request |

## Verification
level, out_valid, out_data and overflow are registered. They are due on the edge that accepts a write, a read or a status read, so the bench drives inputs on the falling edge and checks them on the next falling edge. irq_level is combinational from thr_sel and level, so the table loop checks it within the same cycle after changing thr_sel. irq_timeout is counted from the edge of the last arrival or read. The bench checks that it is still low after 159 further edges and high after the 160th, and it also checks that an arrival inside the window pushes the rise out.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [2:0] {
    THR_ANY  = 3'd0,
    THR_QTR  = 3'd1,
    THR_HALF = 3'd2,
    THR_3QTR = 3'd3,
    THR_FULL = 3'd4
  } thr_code_e;

  // Fill level at which the threshold request asserts for a given code.
  function automatic logic [31:0] thr_fill(input logic [2:0] code,
                                           input logic [31:0] depth);
    case (code)
      THR_ANY:  thr_fill = 32'd1;
      THR_QTR:  thr_fill = depth / 4;
      THR_HALF: thr_fill = depth / 2;
      THR_3QTR: thr_fill = (depth * 3) / 4;
      default:  thr_fill = depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/uart_rxq_idle.sv
module uart_rxq_idle #(
  parameter int LIMIT = 160,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic pop,
  input  logic empty,
  output logic tmo
);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      tmo      <= 1'b0;
    end else begin
      if (arrive || pop || empty)      idle_cnt <= '0;
      else if (idle_cnt != CW'(LIMIT)) idle_cnt <= idle_cnt + 1'b1;

      if (pop)
        tmo <= 1'b0;
      else if (!empty && !arrive && idle_cnt == CW'(LIMIT - 1))
        tmo <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rxq_flags.sv
module uart_rxq_flags
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] count,
  input  logic [2:0]    thr_sel,
  input  logic          drop,
  input  logic          status_rd,
  output logic          lvl_req,
  output logic          ovf
);

  logic [LW-1:0] thr_now;

  assign thr_now = LW'(thr_fill(thr_sel, 32'(DEPTH)));
  assign lvl_req = (count >= thr_now);

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (drop)      ovf <= 1'b1;
    else if (status_rd) ovf <= 1'b0;
  end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH        = 32,
  parameter int DATA_W       = 8,
  parameter int CLK_PER_BIT  = 4,
  parameter int BITS_PER_CHR = 10,
  parameter int IDLE_CHARS   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  input  logic [2:0]             thr_sel,
  input  logic                   status_rd,
  output logic [$clog2(DEPTH):0] level,
  output logic                   overflow,
  output logic                   irq_level,
  output logic                   irq_timeout,
  output logic                   irq
);

  localparam int LW        = $clog2(DEPTH) + 1;
  localparam int IDLE_CYCS = CLK_PER_BIT * BITS_PER_CHR * IDLE_CHARS;

  logic          pop, full, empty, push_ok, drop;
  logic [LW-1:0] count;

  assign empty   = (count == '0);
  assign full    = (count == LW'(DEPTH));
  assign pop     = out_ready && !empty;
  assign push_ok = in_valid && (!full || pop);
  assign drop    = in_valid && full && !pop;

  uart_rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (out_data),
    .count   (count)
  );

  uart_rxq_idle #(.LIMIT(IDLE_CYCS)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .arrive (in_valid),
    .pop    (pop),
    .empty  (empty),
    .tmo    (irq_timeout)
  );

  uart_rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .thr_sel   (thr_sel),
    .drop      (drop),
    .status_rd (status_rd),
    .lvl_req   (irq_level),
    .ovf       (overflow)
  );

  assign out_valid = !empty;
  assign level     = count;
  assign irq       = irq_level || irq_timeout;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   status_rd,
  input logic [$clog2(DEPTH):0] level,
  input logic                   overflow,
  input logic                   irq_timeout
);

  // R2
  valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (level != '0));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_ready && level == ($clog2(DEPTH)+1)'(DEPTH))
      |=> (overflow && level == ($clog2(DEPTH)+1)'(DEPTH)));

  // R8
  rw_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && out_valid) |=> (level == $past(level)));

  // R3
  read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready && out_valid) |=> (level == $past(level) - 1'b1));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !status_rd) |=> overflow);

  // R9
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_timeout && !(out_ready && out_valid)) |=> irq_timeout);

  // R11
  tmo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !irq_timeout);

endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .status_rd   (status_rd),
  .level       (level),
  .overflow    (overflow),
  .irq_timeout (irq_timeout)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;

  localparam int IDLE = 4 * 10 * 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic [2:0] thr_sel = '0;
  logic       status_rd = 1'b0;
  logic       out_valid, overflow, irq_level, irq_timeout, irq;
  logic [7:0] out_data;
  logic [5:0] level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_rxq u_uart_rxq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .thr_sel(thr_sel), .status_rd(status_rd), .level(level),
    .overflow(overflow), .irq_level(irq_level), .irq_timeout(irq_timeout),
    .irq(irq)
  );

  // {thr_sel, fill, expected irq_level}
  localparam logic [9:0] VEC [12] = '{
    {3'd0, 6'd0,  1'b0}, {3'd0, 6'd1,  1'b1},
    {3'd1, 6'd7,  1'b0}, {3'd1, 6'd8,  1'b1},
    {3'd2, 6'd15, 1'b0}, {3'd2, 6'd16, 1'b1},
    {3'd3, 6'd23, 1'b0}, {3'd3, 6'd24, 1'b1},
    {3'd4, 6'd31, 1'b0}, {3'd4, 6'd32, 1'b1},
    {3'd7, 6'd32, 1'b1}, {3'd5, 6'd20, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input bit iv, input logic [7:0] d, input bit ordy, input bit srd);
    in_valid = iv; in_data = d; out_ready = ordy; status_rd = srd;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; status_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) cyc(1'b1, base + 8'(i), 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_timeout", irq_timeout, 0);

    // R4 / R3 threshold table
    foreach (VEC[k]) begin
      do_reset();
      fill(int'(VEC[k][6:1]), 8'h10);
      thr_sel = VEC[k][9:7];
      #1;
      chk("R3 level", level, int'(VEC[k][6:1]));
      chk("R4 irq_level", irq_level, int'(VEC[k][0]));
      chk("R10 irq", irq, int'(VEC[k][0]));
    end

    // R5 deassert on read below threshold
    do_reset();
    thr_sel = 3'd2;
    fill(16, 8'h00);
    chk("R5 irq_level at 16", irq_level, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R5 irq_level at 15", irq_level, 0);
    chk("R3 level after read", level, 15);

    // R6 / R7 / R8 / R2 full handling and order
    do_reset();
    thr_sel = 3'd4;
    fill(32, 8'h40);
    chk("R4 full irq", irq_level, 1);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0);
    chk("R6 overflow", overflow, 1);
    chk("R6 level", level, 32);
    chk("R6 head", out_data, 8'h40);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R7 cleared", overflow, 0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b1);
    chk("R7 set wins", overflow, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R7 cleared again", overflow, 0);
    cyc(1'b1, 8'h77, 1'b1, 1'b0);
    chk("R8 level", level, 32);
    chk("R8 overflow", overflow, 0);
    for (int i = 0; i < 31; i++) begin
      chk("R2 order", out_data, 8'h41 + i);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
    end
    chk("R8 stored byte", out_data, 8'h77);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R2 empty level", level, 0);
    chk("R2 empty valid", out_valid, 0);

    // R11 empty never times out
    do_reset();
    thr_sel = 3'd4;
    idle(IDLE + 10);
    chk("R11 empty", irq_timeout, 0);

    // R9 timeout window
    cyc(1'b1, 8'h5A, 1'b0, 1'b0);
    idle(IDLE - 1);
    chk("R9 before", irq_timeout, 0);
    idle(1);
    chk("R9 rise", irq_timeout, 1);
    chk("R10 irq from timeout", irq, 1);
    idle(5);
    chk("R9 held", irq_timeout, 1);
    cyc(1'b1, 8'h5B, 1'b0, 1'b0);
    chk("R9 arrival keeps", irq_timeout, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R9 read clears", irq_timeout, 0);

    // R11 arrival restarts the count
    do_reset();
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    idle(IDLE - 1);
    cyc(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R11 restart", irq_timeout, 0);
    idle(IDLE - 1);
    chk("R11 before", irq_timeout, 0);
    idle(1);
    chk("R11 rise", irq_timeout, 1);

    finish_run();
  end

endmodule